// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block produces the stop condition for a multi-master I2C controller. Software first writes an arming command to the control port. The block then enters a stop-pending state and pulls both SCL and SDA low. A later write of any value to the data port fires the stop. SCL is released first. Once SCL reads back high, the block waits a setup interval and then releases SDA. It then keeps the sequence closed for a bus-free interval. Both intervals are counted in prescaler ticks, and their lengths depend on the fast-mode select.

The bus-busy flag is derived from what the block observes on the synchronised bus lines. It is set when SDA falls while SCL is high. It is cleared only when SDA rises while SCL is high, so finishing the internal sequence does not by itself free the bus. Writes that arrive while a stop is in flight are dropped, and each dropped write raises a one-cycle flag.

Another device may pull SCL low after SCL has gone high during the stop and before bus-busy clears. In that case the block holds its own SCL low and stays there. The line is freed by re-running the arm-then-fire sequence, by clearing the enable, or by pulsing the soft reset.

Top module: `i2c_stop_gen`

## Requirements
- R1: Reset conditions. After reset, `scl_o` and `sda_o` are 1 (released), `bus_busy` is 0 and `wr_rejected` is 0.
- R2: Arming.
  - With `en`=1 and the block idle, a control write of 8'hC0 drives `sda_o` and `scl_o` to 0 from the next cycle on.
  - A control write of any other value, or any write while `en`=0, leaves both lines released.
- R3: Firing.
  - A data write of any value while armed releases `scl_o` in the next cycle, while `sda_o` stays 0.
  - A data write while idle changes nothing.
- R4: Setup interval. `sda_o` rises between N·P and N·P+8 clock cycles after `scl_o` rises.
  - P is the prescaler of 20 cycles.
  - N is 40 ticks in standard mode (`fast_mode`=0) and 6 ticks in fast mode.
- R5: Bus-busy flag. `bus_busy` sets when the synchronised SDA falls while SCL is high. It clears only when SDA rises while SCL is high, which happens within 8 cycles of the block releasing SDA at the end of a stop.
- R6: Bus-free interval. The stop stays in progress for F·P cycles after `sda_o` rises.
  - F is 47 ticks in standard mode and 13 in fast mode.
  - A write 6 cycles before that point is rejected.
  - A write 6 cycles after it is not rejected.
- R7: Stuck SCL latch. SCL may read low after it has been seen high during the stop's setup phase, or during the hold phase while `bus_busy` is 1. In either case the block drives `scl_o` and `sda_o` to 0 and keeps them there after the other device lets go. `bus_busy` stays 1.
- R8: Recovery. A latched-low SCL is released by any one of three actions:
  - repeating arm (8'hC0) then fire, which completes a normal stop;
  - driving `en` to 0;
  - pulsing `soft_rst`.
- R9: Write protection. A control or data write accepted while a stop is in progress does not alter the sequence. It sets `wr_rejected` to 1 for the single following cycle.
- R10: Abort. `en`=0 or `soft_rst`=1 returns the block to idle in one cycle from any state. From the next cycle on, both lines are released and `bus_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| en | input | 1 | Interface enable |
| soft_rst | input | 1 | Interface soft reset pulse |
| fast_mode | input | 1 | 1 selects fast-mode timing, 0 standard |
| wr_ctrl | input | 1 | Control register write strobe |
| wr_data | input | 1 | Data register write strobe |
| wdata | input | 8 | Write data |
| scl_in | input | 1 | SCL bus level (asynchronous) |
| sda_in | input | 1 | SDA bus level (asynchronous) |
| scl_o | output | 1 | Open-drain SCL drive, 1 = release |
| sda_o | output | 1 | Open-drain SDA drive, 1 = release |
| bus_busy | output | 1 | Bus busy flag |
| wr_rejected | output | 1 | One-cycle pulse for a dropped write |

## Verification
The properties below are checked on every cycle:
- arming and firing move the line drives one cycle after the write;
- a rise of SDA only follows an expired timer or an abort;
- bus-busy only falls on an observed stop or an abort;
- the stuck state keeps SCL low until a recovery action;
- every rejection pulse has a write behind it.

Three things can only be shown by the bench's scenarios on a modelled open-drain bus:
- the actual setup and bus-free cycle counts in each mode;
- the fact that the latch needs a foreign device to pull SCL after it was released;
- that each of the three recovery paths leaves the bus in a usable state.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SCL_RISE,
    ST_SETUP,
    ST_HOLD,
    ST_STUCK
  } stop_state_e;

  localparam logic [7:0] ARM_CMD = 8'hC0;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  // lines idle high, so the chain resets to released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/stop_timer.sv
module stop_timer #(
  parameter int PRESC = 20,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;

  logic [PW-1:0]    pcnt_q, pcnt_d;
  logic [CNT_W-1:0] tcnt_q, tcnt_d;
  logic             run, tick;

  assign run  = (tcnt_q != '0);
  assign tick = (pcnt_q == PW'(PRESC - 1));

  always_comb begin
    pcnt_d = pcnt_q;
    tcnt_d = tcnt_q;
    if (load) begin
      pcnt_d = '0;
      tcnt_d = load_val;
    end else if (run) begin
      if (tick) begin
        pcnt_d = '0;
        tcnt_d = tcnt_q - 1'b1;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      tcnt_q <= '0;
    end else if (load || run) begin
      pcnt_q <= pcnt_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign done = !run;

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic scl_s,
  input  logic sda_s,
  output logic bus_busy,
  output logic stop_seen
);

  logic scl_q, sda_q, busy_q, busy_d;
  logic start_seen;

  assign start_seen = scl_q && scl_s && sda_q && !sda_s;
  assign stop_seen  = scl_q && scl_s && !sda_q && sda_s;

  always_comb begin
    busy_d = busy_q;
    if (clr)             busy_d = 1'b0;
    else if (start_seen) busy_d = 1'b1;
    else if (stop_seen)  busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      busy_q <= busy_d;
    end
  end

  assign bus_busy = busy_q;

endmodule

// File: rtl/i2c_stop_gen.sv
module i2c_stop_gen #(
  parameter int PRESC      = 20,
  parameter int STD_SETUP  = 40,
  parameter int STD_FREE   = 47,
  parameter int FAST_SETUP = 6,
  parameter int FAST_FREE  = 13,
  parameter int SYNC_STG   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       soft_rst,
  input  logic       fast_mode,
  input  logic       wr_ctrl,
  input  logic       wr_data,
  input  logic [7:0] wdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_o,
  output logic       sda_o,
  output logic       bus_busy,
  output logic       wr_rejected
);
  import i2c_stop_pkg::*;

  localparam int MAX_A = (STD_SETUP > FAST_SETUP) ? STD_SETUP : FAST_SETUP;
  localparam int MAX_B = (STD_FREE > FAST_FREE) ? STD_FREE : FAST_FREE;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_T + 1);

  stop_state_e      state, state_d;
  logic [1:0]       lines_s;
  logic             scl_s, sda_s;
  logic             kill, arm_wr, in_stop, stop_seen;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             rej_d;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  assign kill    = !en || soft_rst;
  assign arm_wr  = wr_ctrl && (wdata == ARM_CMD);
  assign in_stop = (state == ST_SCL_RISE) || (state == ST_SETUP) || (state == ST_HOLD);

  i2c_bus_monitor u_mon (
    .clk(clk), .rst_n(rst_n), .clr(kill), .scl_s(scl_s), .sda_s(sda_s),
    .bus_busy(bus_busy), .stop_seen(stop_seen)
  );

  stop_timer #(.PRESC(PRESC), .CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  // next-state logic
  always_comb begin
    state_d  = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE:  if (arm_wr) state_d = ST_ARMED;
      ST_ARMED: if (wr_data) state_d = ST_SCL_RISE;
      ST_SCL_RISE: begin
        if (scl_s) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = fast_mode ? CNT_W'(FAST_SETUP) : CNT_W'(STD_SETUP);
        end
      end
      ST_SETUP: begin
        if (!scl_s) state_d = ST_STUCK;
        else if (tmr_done) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = fast_mode ? CNT_W'(FAST_FREE) : CNT_W'(STD_FREE);
        end
      end
      ST_HOLD: begin
        if (bus_busy && !scl_s)        state_d = ST_STUCK;
        else if (tmr_done && !bus_busy) state_d = ST_IDLE;
      end
      ST_STUCK: if (arm_wr) state_d = ST_ARMED;
      default:  state_d = ST_IDLE;
    endcase
    if (kill) begin
      state_d  = ST_IDLE;
      tmr_load = 1'b0;
    end
  end

  assign rej_d = in_stop && (wr_ctrl || wr_data) && !kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      wr_rejected <= 1'b0;
    end else begin
      state       <= state_d;
      wr_rejected <= rej_d;
    end
  end

  // open-drain drives decoded from state flops
  assign scl_o = !((state == ST_ARMED) || (state == ST_STUCK));
  assign sda_o = !((state == ST_ARMED) || (state == ST_SCL_RISE) ||
                   (state == ST_SETUP) || (state == ST_STUCK));

endmodule

// File: rtl/i2c_stop_chk.sv
module i2c_stop_chk (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      en,
  input logic                      soft_rst,
  input logic                      wr_ctrl,
  input logic                      wr_data,
  input logic [7:0]                wdata,
  input logic                      scl_o,
  input logic                      sda_o,
  input logic                      bus_busy,
  input logic                      wr_rejected,
  input i2c_stop_pkg::stop_state_e state,
  input logic                      stop_seen,
  input logic                      tmr_done
);
  import i2c_stop_pkg::*;

  p_arm_drives_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !soft_rst && wr_ctrl && wdata == ARM_CMD && state == ST_IDLE) |=> (!sda_o && !scl_o));

  p_fire_frees_scl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !soft_rst && wr_data && state == ST_ARMED) |=> (scl_o && !sda_o));

  p_sda_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_o) |-> $past(tmr_done || !en || soft_rst));

  p_busy_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> $past(stop_seen || !en || soft_rst));

  p_hold_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && bus_busy && en && !soft_rst) |=> (state == ST_HOLD || state == ST_STUCK));

  p_stuck_keeps_scl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STUCK && en && !soft_rst && !(wr_ctrl && wdata == ARM_CMD)) |=> !scl_o);

  p_reject_has_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rejected |-> $past(wr_ctrl || wr_data));

  p_abort_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || soft_rst) |=> (scl_o && sda_o && !bus_busy));

endmodule

bind i2c_stop_gen i2c_stop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .soft_rst(soft_rst),
  .wr_ctrl(wr_ctrl), .wr_data(wr_data), .wdata(wdata),
  .scl_o(scl_o), .sda_o(sda_o), .bus_busy(bus_busy), .wr_rejected(wr_rejected),
  .state(state), .stop_seen(stop_seen), .tmr_done(tmr_done)
);

// File: tb/tb_i2c_stop_gen.sv
`timescale 1ns/1ps
module tb_i2c_stop_gen;
  localparam int P = 20, SS = 40, SF = 6, FS = 47, FF = 13;

  logic clk, rst_n, en, soft_rst, fast_mode, wr_ctrl, wr_data;
  logic [7:0] wdata;
  logic tb_scl_pull, tb_sda_pull;
  logic scl_o, sda_o, bus_busy, wr_rejected;
  wire  scl_line = scl_o & ~tb_scl_pull;
  wire  sda_line = sda_o & ~tb_sda_pull;

  int tests, fails, cyc;

  i2c_stop_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .soft_rst(soft_rst), .fast_mode(fast_mode),
    .wr_ctrl(wr_ctrl), .wr_data(wr_data), .wdata(wdata),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_o(scl_o), .sda_o(sda_o), .bus_busy(bus_busy), .wr_rejected(wr_rejected)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int exp_setup(bit f);
    return (f ? SF : SS) * P;
  endfunction
  function automatic int exp_free(bit f);
    return (f ? FF : FS) * P;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_c(input logic [7:0] v);
    wr_ctrl = 1'b1; wdata = v; tick(1); wr_ctrl = 1'b0;
  endtask

  task automatic wr_d(input logic [7:0] v);
    wr_data = 1'b1; wdata = v; tick(1); wr_data = 1'b0;
  endtask

  // another master opens a transfer: start condition, then SCL low
  task automatic begin_xfer();
    tb_sda_pull = 1'b1; tick(5);
    chk(bus_busy == 1'b1, "R5 start sets busy", int'(bus_busy), 1);
    tb_scl_pull = 1'b1; tick(3);
  endtask

  task automatic arm();
    wr_c(8'hC0);
    chk(!sda_o && !scl_o, "R2 arm drives low", int'({scl_o, sda_o}), 0);
    tb_sda_pull = 1'b0; tb_scl_pull = 1'b0; tick(2);
  endtask

  // fire, optionally poke a write mid-setup, measure setup gap
  task automatic fire_measure(input bit mid);
    int cnt;
    wr_d($urandom % 256);
    chk(scl_o && !sda_o, "R3 fire releases scl", int'({scl_o, sda_o}), 2);
    cnt = 0;
    while (!sda_o && cnt < 2000) begin
      if (mid && cnt == 20) begin wr_ctrl = 1'b1; wdata = 8'hC0; end
      else wr_ctrl = 1'b0;
      tick(1); cnt++;
      if (mid && cnt == 21)
        chk(wr_rejected && !sda_o, "R9 mid-stop write rejected", int'({wr_rejected, sda_o}), 2);
    end
    wr_ctrl = 1'b0;
    chk(cnt >= exp_setup(fast_mode) && cnt <= exp_setup(fast_mode) + 8,
        "R4 setup interval", cnt, exp_setup(fast_mode));
  endtask

  // after sda release: busy clears, then bus-free window
  task automatic finish_stop(input bit probe);
    int k;
    k = 0;
    while (bus_busy && k < 20) begin tick(1); k++; end
    chk(!bus_busy && k <= 8, "R5 stop clears busy", k, 8);
    if (probe) begin
      tick(exp_free(fast_mode) - 6 - k - 1);
      wr_d(8'h11);
      chk(wr_rejected == 1'b1, "R6 write inside bus-free rejected", int'(wr_rejected), 1);
      tick(10);
      wr_d(8'h22);
      chk(!wr_rejected && scl_o && sda_o, "R6 write after bus-free accepted idle",
          int'({wr_rejected, scl_o, sda_o}), 3);
    end else begin
      tick(exp_free(fast_mode) + 4);
    end
  endtask

  task automatic stuck_case(input int how);
    wr_d(8'h00);
    tick(12);
    tb_scl_pull = 1'b1; tick(4); tb_scl_pull = 1'b0; tick(3);
    chk(!scl_o && !sda_o, "R7 scl latched low", int'({scl_o, sda_o}), 0);
    tick(25);
    chk(!scl_o && bus_busy, "R7 latch persists busy held", int'({scl_o, bus_busy}), 1);
    case (how)
      0: begin
        wr_c(8'hC0); tick(1);
        fire_measure(1'b0);
        chk(sda_o == 1'b1, "R8 rearm recovery completes", int'(sda_o), 1);
        finish_stop(1'b0);
      end
      1: begin
        en = 1'b0; tick(1); en = 1'b1;
        chk(scl_o && sda_o && !bus_busy, "R8 disable recovery", int'({scl_o, sda_o, bus_busy}), 6);
        tick(6);
      end
      default: begin
        soft_rst = 1'b1; tick(1); soft_rst = 1'b0;
        chk(scl_o && sda_o && !bus_busy, "R8 soft reset recovery", int'({scl_o, sda_o, bus_busy}), 6);
        tick(6);
      end
    endcase
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; cyc = 0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; en = 1'b1; soft_rst = 1'b0; fast_mode = 1'b0;
    wr_ctrl = 1'b0; wr_data = 1'b0; wdata = '0;
    tb_scl_pull = 1'b0; tb_sda_pull = 1'b0;
    tick(4); rst_n = 1'b1; tick(2);

    chk(scl_o && sda_o && !bus_busy && !wr_rejected, "R1 reset state",
        int'({scl_o, sda_o, bus_busy, wr_rejected}), 12);

    wr_c(8'h80);
    chk(scl_o && sda_o, "R2 wrong command ignored", int'({scl_o, sda_o}), 3);
    en = 1'b0; wr_c(8'hC0); tick(1);
    chk(scl_o && sda_o, "R2 arm while disabled ignored", int'({scl_o, sda_o}), 3);
    en = 1'b1; tick(2);
    wr_d(8'h55);
    chk(scl_o && sda_o && !wr_rejected, "R3 idle data write no effect",
        int'({scl_o, sda_o, wr_rejected}), 6);

    // directed: standard stop with bus-free probes
    begin_xfer(); arm(); fire_measure(1'b0); finish_stop(1'b1);
    // directed: fast mode with mid-setup rejected write
    fast_mode = 1'b1;
    begin_xfer(); arm(); fire_measure(1'b1); finish_stop(1'b1);
    // directed: abort while armed
    begin_xfer(); arm();
    soft_rst = 1'b1; tick(1); soft_rst = 1'b0;
    chk(scl_o && sda_o && !bus_busy, "R10 abort while armed", int'({scl_o, sda_o, bus_busy}), 6);
    tick(4);
    // directed: stuck with each recovery
    for (int h = 0; h < 3; h++) begin
      begin_xfer(); arm(); stuck_case(h);
    end

    // constrained random mix
    for (int i = 0; i < 24; i++) begin
      fast_mode = $urandom % 2;
      tick(2);
      begin_xfer(); arm();
      case ($urandom % 3)
        0: begin fire_measure(1'b0); finish_stop($urandom % 2); end
        1: begin fire_measure(1'b1); finish_stop(1'b0); end
        default: stuck_case($urandom % 3);
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule